// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block sits in front of one memory channel and gathers full-word stores into line-sized entries. A store that falls in a line already held is merged into that entry. A store to a new line takes a fresh entry. Entries are not sent one at a time. They pile up until a batch is due, and the whole batch then goes to the memory controller back to back. Grouping writes this way means the shared data bus turns around between reads and writes less often. While a batch is running, `drain_active` stays high so the controller can hold off its reads.

Only whole 32-bit stores enter the buffer. A store with any byte-enable bit low, or one flagged atomic, is handed straight to a side port. That port feeds a slower path that can do read-modify-write. Each line write carries the merged line data and a per-byte mask. Bytes that no store touched have a mask bit of 0 and read as zero. Entries leave in the order they were allocated.

The batch controller has three states. In FILL it only collects. It moves FILL→BATCH when occupancy reaches the high watermark, and FILL→FLUSH when `flush` is seen. In BATCH it drains while occupancy is above the low watermark. It moves BATCH→FILL once occupancy is at or below the low watermark, and BATCH→FLUSH on `flush`. In FLUSH it drains everything and moves FLUSH→FILL when the buffer is empty.

Top module: `wcb_store_combiner`

## Requirements
- R1: A store with `st_atomic`=1 or with `st_be` not equal to 4'hF appears on the side port in the same cycle. Its handshake there is `st_ready`=`rej_ready`, and it never creates or modifies a buffer entry.
- R2: Full-word stores to the same 64-byte line, made while that line is not being presented on the write port, leave as a single line write. Each 32-bit word sits at byte offset `st_addr[5:2]`*4, and a later store to a word replaces the earlier value.
- R3: `wr_mask` bit b is 1 exactly when some merged store wrote byte b of the line. `wr_data` byte b is zero when its mask bit is 0.
- R4: A batch starts only through BATCH or FLUSH. `drain_active` rises on the second clock edge after the store that brings occupancy to 48. It stays low while occupancy is below 48 and no flush has been seen.
- R5: A batch started by the high watermark with no new stores emits exactly occupancy−8 line writes. `drain_active` then falls, and 8 entries remain.
- R6: A one-cycle `flush` pulse drains every held entry, after which `drain_active` falls.
- R7: Line writes leave in the order in which their entries were allocated.
- R8: With 64 entries held, a store that misses every entry sees `st_ready`=0. A store that hits a held line other than the one at the write port is still accepted.
- R9: `wr_valid` is high only while `drain_active` is high. While `wr_valid` is high and `wr_ready` is low, the presented line address and mask hold steady.
- R10: After reset the buffer is empty, `drain_active` and `wr_valid` are low, and `st_ready` is high for a full-word store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store accepted this cycle (buffer or side port) |
| st_addr | input | AW | Byte address of the store |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Byte enables of the store |
| st_atomic | input | 1 | Store is an atomic operation |
| flush | input | 1 | Request to drain every held entry |
| rej_valid | output | 1 | Diverted store valid on the side port |
| rej_ready | input | 1 | Side port can take the store |
| rej_addr | output | AW | Diverted store address |
| rej_data | output | 32 | Diverted store data |
| rej_be | output | 4 | Diverted store byte enables |
| rej_atomic | output | 1 | Diverted store atomic flag |
| wr_valid | output | 1 | Line write request valid |
| wr_ready | input | 1 | Memory controller takes the line write |
| wr_line_addr | output | AW-6 | Line address (byte address divided by 64) |
| wr_data | output | 512 | Merged line data |
| wr_mask | output | 64 | Per-byte write mask |
| drain_active | output | 1 | A drain batch is in progress |

## Verification
A wrong entry-ring pointer or occupancy count shows up at the write port. The effect is a line write that arrives out of allocation order, a duplicated line, or a batch that stops after the wrong number of writes. Any of these appears at the first write of the next batch. A faulty merge shows up when that line is written, as wrong data or a wrong mask. A controller stuck in the wrong state shows up within two cycles as `drain_active` disagreeing with the occupancy and the watermarks. Misrouting of sub-word or atomic stores shows up in the same cycle on `rej_valid`. A wrongly routed store also adds an extra line to the next drain.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
    localparam int WORD_BITS  = 32;
    localparam int WORD_BYTES = WORD_BITS / 8;

    typedef enum logic [1:0] {
        CTL_FILL  = 2'd0,
        CTL_BATCH = 2'd1,
        CTL_FLUSH = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/wcb_route.sv
module wcb_route
    import wcb_pkg::*;
(
    input  logic                  st_valid,
    input  logic [WORD_BYTES-1:0] st_be,
    input  logic                  st_atomic,
    input  logic                  rej_ready,
    input  logic                  buf_ready,
    output logic                  rej_valid,
    output logic                  st_ready,
    output logic                  buf_fire
);
    logic divert;

    always_comb begin
        divert    = st_atomic || (st_be != {WORD_BYTES{1'b1}});
        rej_valid = st_valid && divert;
        st_ready  = divert ? rej_ready : buf_ready;
        buf_fire  = st_valid && !divert && buf_ready;
    end
endmodule

// File: rtl/wcb_line_ring.sv
module wcb_line_ring
    import wcb_pkg::*;
#(
    parameter int LINES      = 64,
    parameter int LINE_BYTES = 64,
    parameter int TAGW       = 26,
    localparam int IDXW  = $clog2(LINES),
    localparam int OCCW  = IDXW + 1,
    localparam int WORDS = LINE_BYTES / WORD_BYTES,
    localparam int WSELW = $clog2(WORDS),
    localparam int DW    = LINE_BYTES * 8
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  st_fire,
    input  logic [TAGW-1:0]       st_tag,
    input  logic [WSELW-1:0]      st_wsel,
    input  logic [WORD_BITS-1:0]  st_data,
    input  logic [WORD_BYTES-1:0] st_be,
    input  logic                  excl_head,
    input  logic                  pop,
    output logic                  hit,
    output logic                  full,
    output logic [TAGW-1:0]       head_tag,
    output logic [DW-1:0]         head_data,
    output logic [LINE_BYTES-1:0] head_mask,
    output logic [OCCW-1:0]       occ
);
    localparam logic [OCCW-1:0] FULL_OCC = OCCW'(LINES);

    logic [TAGW-1:0]       tag_q  [LINES];
    logic [DW-1:0]         data_q [LINES];
    logic [LINE_BYTES-1:0] mask_q [LINES];
    logic [LINES-1:0]      vld_q;
    logic [IDXW-1:0]       head_q, tail_q;
    logic [OCCW-1:0]       occ_q;

    logic [LINES-1:0]      hit_vec;
    logic [IDXW-1:0]       hit_idx;
    logic                  alloc;
    logic [DW-1:0]         word_ins;
    logic [LINE_BYTES-1:0] mask_ins;
    logic [DW-1:0]         merged;

    // tag match over live entries; the line at the write port is left out
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < LINES; i++) begin
            hit_vec[i] = vld_q[i] && (tag_q[i] == st_tag) &&
                         !(excl_head && (IDXW'(i) == head_q));
            if (hit_vec[i]) hit_idx = IDXW'(i);
        end
        hit = |hit_vec;
    end

    always_comb begin
        full     = (occ_q == FULL_OCC);
        alloc    = st_fire && !hit;
        word_ins = DW'(st_data) << {st_wsel, 5'b0};
        mask_ins = LINE_BYTES'(st_be) << {st_wsel, 2'b0};
        for (int b = 0; b < LINE_BYTES; b++) begin
            merged[b*8 +: 8] = mask_ins[b] ? word_ins[b*8 +: 8]
                                           : data_q[hit_idx][b*8 +: 8];
        end
    end

    // control state: pointers, valid bits, occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else begin
            if (pop) begin
                vld_q[head_q] <= 1'b0;
                head_q        <= head_q + 1'b1;
            end
            if (alloc) begin
                vld_q[tail_q] <= 1'b1;
                tail_q        <= tail_q + 1'b1;
            end
            occ_q <= occ_q + OCCW'(alloc) - OCCW'(pop);
        end
    end

    // payload: a new entry starts all-zero, a hit overlays its bytes
    always_ff @(posedge clk) begin
        if (alloc) begin
            tag_q[tail_q]  <= st_tag;
            data_q[tail_q] <= word_ins;
            mask_q[tail_q] <= mask_ins;
        end else if (st_fire) begin
            data_q[hit_idx] <= merged;
            mask_q[hit_idx] <= mask_q[hit_idx] | mask_ins;
        end
    end

    always_comb begin
        head_tag  = tag_q[head_q];
        head_data = data_q[head_q];
        head_mask = mask_q[head_q];
        occ       = occ_q;
    end
endmodule

// File: rtl/wcb_batch_ctl.sv
module wcb_batch_ctl
    import wcb_pkg::*;
#(
    parameter int OCCW    = 7,
    parameter int HI_MARK = 48,
    parameter int LO_MARK = 8
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [OCCW-1:0] occ,
    input  logic            wr_ready,
    output logic            wr_valid,
    output logic            pop,
    output logic            drain_active
);
    localparam logic [OCCW-1:0] HI_OCC = OCCW'(HI_MARK);
    localparam logic [OCCW-1:0] LO_OCC = OCCW'(LO_MARK);

    ctl_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CTL_FILL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_FILL: begin
                if (flush)             state_d = CTL_FLUSH;
                else if (occ >= HI_OCC) state_d = CTL_BATCH;
            end
            CTL_BATCH: begin
                if (flush)              state_d = CTL_FLUSH;
                else if (occ <= LO_OCC) state_d = CTL_FILL;
            end
            CTL_FLUSH: begin
                if (occ == '0) state_d = CTL_FILL;
            end
            default: state_d = CTL_FILL;
        endcase
    end

    always_comb begin
        wr_valid     = 1'b0;
        drain_active = 1'b0;
        unique case (state_q)
            CTL_FILL: begin
                wr_valid     = 1'b0;
                drain_active = 1'b0;
            end
            CTL_BATCH: begin
                wr_valid     = (occ > LO_OCC);
                drain_active = 1'b1;
            end
            CTL_FLUSH: begin
                wr_valid     = (occ != '0);
                drain_active = 1'b1;
            end
            default: begin
                wr_valid     = 1'b0;
                drain_active = 1'b0;
            end
        endcase
        pop = wr_valid && wr_ready;
    end
endmodule

// File: rtl/wcb_store_combiner.sv
module wcb_store_combiner
    import wcb_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CAP_BYTES  = 4096,
    parameter int LINE_BYTES = 64,
    parameter int HI_MARK    = 48,
    parameter int LO_MARK    = 8,
    localparam int LINES = CAP_BYTES / LINE_BYTES,
    localparam int OFFW  = $clog2(LINE_BYTES),
    localparam int TAGW  = AW - OFFW,
    localparam int OCCW  = $clog2(LINES) + 1,
    localparam int DW    = LINE_BYTES * 8
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  st_valid,
    output logic                  st_ready,
    input  logic [AW-1:0]         st_addr,
    input  logic [WORD_BITS-1:0]  st_data,
    input  logic [WORD_BYTES-1:0] st_be,
    input  logic                  st_atomic,
    input  logic                  flush,
    output logic                  rej_valid,
    input  logic                  rej_ready,
    output logic [AW-1:0]         rej_addr,
    output logic [WORD_BITS-1:0]  rej_data,
    output logic [WORD_BYTES-1:0] rej_be,
    output logic                  rej_atomic,
    output logic                  wr_valid,
    input  logic                  wr_ready,
    output logic [TAGW-1:0]       wr_line_addr,
    output logic [DW-1:0]         wr_data,
    output logic [LINE_BYTES-1:0] wr_mask,
    output logic                  drain_active
);
    localparam int WSEL_LO = $clog2(WORD_BYTES);

    logic            buf_ready, buf_fire, hit, full, pop;
    logic [OCCW-1:0] occ;

    assign buf_ready  = hit || !full;
    assign rej_addr   = st_addr;
    assign rej_data   = st_data;
    assign rej_be     = st_be;
    assign rej_atomic = st_atomic;

    wcb_route u_route (
        .st_valid  (st_valid),
        .st_be     (st_be),
        .st_atomic (st_atomic),
        .rej_ready (rej_ready),
        .buf_ready (buf_ready),
        .rej_valid (rej_valid),
        .st_ready  (st_ready),
        .buf_fire  (buf_fire)
    );

    wcb_line_ring #(
        .LINES      (LINES),
        .LINE_BYTES (LINE_BYTES),
        .TAGW       (TAGW)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_fire   (buf_fire),
        .st_tag    (st_addr[AW-1:OFFW]),
        .st_wsel   (st_addr[OFFW-1:WSEL_LO]),
        .st_data   (st_data),
        .st_be     (st_be),
        .excl_head (wr_valid),
        .pop       (pop),
        .hit       (hit),
        .full      (full),
        .head_tag  (wr_line_addr),
        .head_data (wr_data),
        .head_mask (wr_mask),
        .occ       (occ)
    );

    wcb_batch_ctl #(
        .OCCW    (OCCW),
        .HI_MARK (HI_MARK),
        .LO_MARK (LO_MARK)
    ) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush),
        .occ          (occ),
        .wr_ready     (wr_ready),
        .wr_valid     (wr_valid),
        .pop          (pop),
        .drain_active (drain_active)
    );
endmodule

// File: rtl/wcb_store_combiner_chk.sv
module wcb_store_combiner_chk #(
    parameter int LINES      = 64,
    parameter int LINE_BYTES = 64,
    parameter int TAGW       = 26,
    parameter int OCCW       = 7,
    parameter int HI_MARK    = 48,
    parameter int LO_MARK    = 8
)(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  st_valid,
    input logic [3:0]            st_be,
    input logic                  st_atomic,
    input logic                  flush,
    input logic                  rej_valid,
    input logic                  wr_valid,
    input logic                  wr_ready,
    input logic [TAGW-1:0]       wr_line_addr,
    input logic [LINE_BYTES-1:0] wr_mask,
    input logic                  drain_active,
    input logic [OCCW-1:0]       occ
);
    // R1
    divert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && (st_atomic || st_be != 4'hF) |-> rej_valid);

    // R1
    no_alloc_on_divert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid |=> occ <= $past(occ));

    // R3
    mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_mask != '0);

    // R4
    batch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drain_active) |-> ($past(occ) >= OCCW'(HI_MARK)) || $past(flush));

    // R5
    batch_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drain_active) |-> $past(occ) <= OCCW'(LO_MARK));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCCW'(LINES));

    // R9
    valid_in_batch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> drain_active);

    // R9
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_line_addr) && $stable(wr_mask));
endmodule

bind wcb_store_combiner wcb_store_combiner_chk #(
    .LINES      (LINES),
    .LINE_BYTES (LINE_BYTES),
    .TAGW       (TAGW),
    .OCCW       (OCCW),
    .HI_MARK    (HI_MARK),
    .LO_MARK    (LO_MARK)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .st_valid     (st_valid),
    .st_be        (st_be),
    .st_atomic    (st_atomic),
    .flush        (flush),
    .rej_valid    (rej_valid),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_line_addr (wr_line_addr),
    .wr_mask      (wr_mask),
    .drain_active (drain_active),
    .occ          (occ)
);

// File: tb/wcb_store_combiner_tb_top.sv
module wcb_store_combiner_tb_top;
    localparam int AW = 32;
    localparam int LB = 64;
    localparam int TW = AW - 6;
    localparam int DW = LB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic          st_ready;
    logic [AW-1:0] st_addr = '0;
    logic [31:0]   st_data = '0;
    logic [3:0]    st_be = 4'hF;
    logic          st_atomic = 1'b0;
    logic          flush = 1'b0;
    logic          rej_valid;
    logic          rej_ready = 1'b1;
    logic [AW-1:0] rej_addr;
    logic [31:0]   rej_data;
    logic [3:0]    rej_be;
    logic          rej_atomic;
    logic          wr_valid;
    logic          wr_ready = 1'b1;
    logic [TW-1:0] wr_line_addr;
    logic [DW-1:0] wr_data;
    logic [LB-1:0] wr_mask;
    logic          drain_active;

    int checks = 0;
    int errors = 0;
    int n_wr   = 0;

    logic [TW-1:0] m_tag  [$];
    logic [DW-1:0] m_data [$];
    logic [LB-1:0] m_mask [$];

    always #10 clk = ~clk;

    wcb_store_combiner dut_i (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be), .st_atomic(st_atomic),
        .flush(flush),
        .rej_valid(rej_valid), .rej_ready(rej_ready), .rej_addr(rej_addr),
        .rej_data(rej_data), .rej_be(rej_be), .rej_atomic(rej_atomic),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_line_addr(wr_line_addr),
        .wr_data(wr_data), .wr_mask(wr_mask), .drain_active(drain_active)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected-line model: merge into a held line or append in allocation order
    task automatic model_store(input logic [AW-1:0] a, input logic [31:0] d);
        int idx = -1;
        int w = int'(a[5:2]);
        for (int i = 0; i < m_tag.size(); i++)
            if (m_tag[i] == a[AW-1:6]) idx = i;
        if (idx < 0) begin
            m_tag.push_back(a[AW-1:6]);
            m_data.push_back('0);
            m_mask.push_back('0);
            idx = m_tag.size() - 1;
        end
        m_data[idx][w*32 +: 32] = d;
        m_mask[idx][w*4 +: 4]   = 4'hF;
    endtask

    // driver: called just after a rising edge
    task automatic put(input logic [AW-1:0] a, input logic [31:0] d);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = 4'hF; st_atomic = 1'b0;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (st_ready) break;
        end
        @(posedge clk);
        model_store(a, d);
        #1 st_valid = 1'b0;
    endtask

    task automatic pulse_flush();
        flush = 1'b1;
        @(posedge clk);
        #1 flush = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (!drain_active) break;
        end
        @(posedge clk);
        #1;
    endtask

    // monitor: pop and compare at every write handshake
    always @(negedge clk) begin
        if (rst_n && wr_valid && wr_ready) begin
            n_wr++;
            if (m_tag.size() == 0) begin
                chk(1'b0, "R7 unexpected line write", DW'(wr_line_addr), '0);
            end else begin
                chk(wr_line_addr == m_tag[0], "R7 line order", DW'(wr_line_addr), DW'(m_tag[0]));
                chk(wr_data == m_data[0], "R2 merged data", wr_data, m_data[0]);
                chk(wr_mask == m_mask[0], "R3 byte mask", DW'(wr_mask), DW'(m_mask[0]));
                void'(m_tag.pop_front());
                void'(m_data.pop_front());
                void'(m_mask.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        st_valid = 1'b1; st_be = 4'hF;
        @(negedge clk);
        // R10 reset state
        chk(!drain_active, "R10 drain_active", DW'(drain_active), '0);
        chk(!wr_valid, "R10 wr_valid", DW'(wr_valid), '0);
        chk(st_ready, "R10 st_ready", DW'(st_ready), 1);
        st_valid = 1'b0;
        @(posedge clk); #1;

        // R1 sub-word and atomic stores go to the side port
        st_valid = 1'b1; st_addr = 32'h1004; st_data = 32'hDEAD; st_be = 4'h3;
        @(negedge clk);
        chk(rej_valid && st_ready, "R1 subword diverted", {rej_valid, st_ready}, 2'b11);
        chk(rej_addr == 32'h1004, "R1 side address", DW'(rej_addr), DW'(32'h1004));
        rej_ready = 1'b0;
        @(negedge clk);
        chk(!st_ready && rej_valid, "R1 side backpressure", {rej_valid, st_ready}, 2'b10);
        rej_ready = 1'b1; st_be = 4'hF; st_atomic = 1'b1;
        @(negedge clk);
        chk(rej_valid && rej_atomic, "R1 atomic diverted", {rej_valid, rej_atomic}, 2'b11);
        @(posedge clk); #1;
        st_valid = 1'b0; st_atomic = 1'b0;

        // R2 R3 R6 merge two lines, then flush
        put(32'h1000, 32'h11111111);
        put(32'h1014, 32'h55555555);
        put(32'h1000, 32'hAAAA0000);
        put(32'h203C, 32'hCAFEF00D);
        repeat (4) @(negedge clk);
        chk(!drain_active && n_wr == 0, "R4 no batch below watermark", DW'(n_wr), '0);
        @(posedge clk); #1;
        pulse_flush();
        wait_idle();
        chk(n_wr == 2, "R6 flush writes", DW'(n_wr), 2);
        chk(m_tag.size() == 0, "R6 all drained", DW'(m_tag.size()), '0);

        // R4 R5 watermark batch
        for (int i = 0; i < 47; i++) put(32'h10000 + i*64 + (i%16)*4, 32'h100 + i);
        repeat (5) @(negedge clk);
        chk(!drain_active && !wr_valid, "R4 idle at 47", DW'(drain_active), '0);
        @(posedge clk); #1;
        base = n_wr;
        put(32'h10000 + 47*64, 32'h1FF);
        @(negedge clk);
        chk(!drain_active, "R4 not yet after first edge", DW'(drain_active), '0);
        @(negedge clk);
        chk(drain_active, "R4 batch started", DW'(drain_active), 1);
        @(posedge clk); #1;
        wait_idle();
        chk(n_wr - base == 40, "R5 batch write count", DW'(n_wr - base), 40);
        chk(m_tag.size() == 8, "R5 entries left", DW'(m_tag.size()), 8);
        pulse_flush();
        wait_idle();
        chk(m_tag.size() == 0, "R6 drained to empty", DW'(m_tag.size()), '0);

        // R8 full buffer with the write port stalled
        wr_ready = 1'b0;
        for (int i = 0; i < 64; i++) put(32'h20000 + i*64, 32'h200 + i);
        st_valid = 1'b1; st_addr = 32'h30000; st_data = 32'h777; st_be = 4'hF;
        repeat (3) @(negedge clk);
        chk(!st_ready, "R8 miss stalls when full", DW'(st_ready), '0);
        @(posedge clk); #1;
        st_addr = 32'h20000 + 10*64 + 8; st_data = 32'h88888888;
        @(negedge clk);
        chk(st_ready, "R8 hit accepted when full", DW'(st_ready), 1);
        @(posedge clk);
        model_store(32'h20000 + 10*64 + 8, 32'h88888888);
        #1 st_valid = 1'b0;
        base = n_wr;
        wr_ready = 1'b1;
        wait_idle();
        chk(n_wr - base == 56, "R5 full batch count", DW'(n_wr - base), 56);
        pulse_flush();
        wait_idle();
        put(32'h30000, 32'h777);
        pulse_flush();
        wait_idle();
        chk(m_tag.size() == 0, "R7 all lines written in order", DW'(m_tag.size()), '0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule